// File: doc/BRIEF.md
# Page-Mode Read Port with Identifier Codes

This block is the read side of a 16-bit-wide read-only array that can also be read eight bits at a time. Reads are timed in clock cycles. An access that opens a new page takes the full latency. After that, any change of selection inside the open page takes half as long. A page is eight words, or sixteen bytes in byte mode. A data-valid strobe rises once the selected word or byte is on the outputs, and it stays high while the inputs stay the same.

The output side is a 16-bit data bus with separate enables for the low and high halves. In word mode both halves drive data. In byte mode only the low half drives, and a byte-select input picks which half of the addressed word appears there. An identification request, made while every address bit above bit 0 is low, replaces the array with two fixed identifier words. Address bit 0 low selects the maker code and bit 0 high selects the device code. Bit 15 of each identifier is set so that the whole word has an odd number of ones.

The array contents come from a fixed formula. This lets the block elaborate at any size without loading a file.

Top module: `pgrom_reader`

## Requirements
- R1: While reset is held and chip enable is inactive, `valid` is 0, both output enables are 0 and `dq_o` is 0.
- R2: The first access after chip enable goes low, and any access whose page differs from the open one, raises `valid` FULL_LAT rising edges after the edge that captures the new inputs (edge E0 captures, `valid` is high after edge E0+FULL_LAT). A change into or out of identification mode counts as a page change.
- R3: Inside the open page, a change of address bits [2:0], of `word_mode`, or (in byte mode) of `bsel` raises `valid` PAGE_LAT = FULL_LAT/2 edges after the capturing edge. `valid` is 0 in between.
- R4: Chip enable high (`ce_n`=1) at a rising edge clears `valid` after that edge and closes the page.
- R5: `dq_oe_lo` = !ce_n & !oe_n. `dq_oe_hi` = `dq_oe_lo` & `word_mode`. Any disabled half of `dq_o` reads 0.
- R6: In word mode (`word_mode`=1) with `valid`, `dq_o` is the array word at `addr`, where word(a) = bits [15:0] of (a*0x9E37 + 0x1234).
- R7: In byte mode (`word_mode`=0), `dq_o[7:0]` is word bits [7:0] when `bsel`=0 and bits [15:8] when `bsel`=1, and `dq_o[15:8]` is 0. In word mode a change of `bsel` neither restarts an access nor changes the data.
- R8: Identification mode is active when `id_req`=1 and addr[ADDR_W-1:1]=0. `addr[0]`=0 returns MFR_CODE and 1 returns DEV_CODE in bits [14:0]. Bit 15 gives the 16-bit word odd parity.
- R9: With `id_req`=1 but any address bit above bit 0 set, the block reads the array as in R6.
- R10: `oe_n` affects only the output enables. Toggling it neither clears `valid` nor changes the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| bsel | input | 1 | Byte select in byte mode (0 low byte, 1 high byte) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 word width, 0 byte width |
| id_req | input | 1 | Identification-mode request |
| dq_o | output | 16 | Data bus |
| dq_oe_lo | output | 1 | Drive enable for dq_o[7:0] |
| dq_oe_hi | output | 1 | Drive enable for dq_o[15:8] |
| valid | output | 1 | Data-valid strobe |

## Verification
The hold and parity properties assume that inputs change at most once per clock and never within a setup window of the rising edge. They also assume that a `valid` seen with unchanged inputs belongs to those inputs. The bench therefore changes every input at the falling edge and samples at the next falling edge. It holds each selection still until `valid` has been observed, so no access is cut short by a second change that the checker would read as a restart.

// File: rtl/pgrom_pkg.sv
// Shared definitions for the page-mode read port.
// Assumes a 16-bit array word; the fill formula stands in for programmed contents.
package pgrom_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // Array contents as a pure function of the word address.
    function automatic logic [WORD_W-1:0] fill_word(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'h0000_9E37 + 32'h0000_1234;
        return t[WORD_W-1:0];
    endfunction

    // Identifier word: 15 code bits plus a top bit that makes total parity odd.
    function automatic logic [WORD_W-1:0] id_word(input logic [WORD_W-2:0] code);
        return {~^code, code};
    endfunction

endpackage

// File: rtl/pgrom_store.sv
// Read-only array of 2**ADDR_W words, filled from pgrom_pkg::fill_word.
// Assumes ADDR_W is small enough for a flat array at elaboration.
module pgrom_store #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [pgrom_pkg::WORD_W-1:0]  rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [pgrom_pkg::WORD_W-1:0] mem [DEPTH];

    // Fill every location from the content formula.
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign mem[i] = pgrom_pkg::fill_word(32'(i));
    end

    // Asynchronous read of the addressed word.
    assign rd_word = mem[addr];

endmodule

// File: rtl/pgrom_timer.sv
// Page tracker and latency counter.
// Assumes that tag names the page and sel names the position inside it.
// A tag change, or a closed page, loads FULL_LAT-1; a sel change loads PAGE_LAT-1.
// load_o is high at each edge where the count has run out and nothing has changed.
module pgrom_timer #(
    parameter int TAG_W    = 8,
    parameter int SEL_W    = 5,
    parameter int FULL_LAT = 4,
    parameter int PAGE_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic [TAG_W-1:0] tag,
    input  logic [SEL_W-1:0] sel,
    output logic             load_o,
    output logic             valid_o
);
    localparam int CW = $clog2(FULL_LAT + 1);

    logic             page_open;
    logic [TAG_W-1:0] open_tag;
    logic [SEL_W-1:0] last_sel;
    logic [CW-1:0]    cnt;
    logic             new_page;
    logic             new_sel;

    // Classify the current inputs against the open page.
    always_comb begin
        new_page = !page_open || (tag != open_tag);
        new_sel  = (sel != last_sel);
        load_o   = !ce_n && !new_page && !new_sel && (cnt == '0);
    end

    // Track the open page, the latency countdown and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_open <= 1'b0;
            open_tag  <= '0;
            last_sel  <= '0;
            cnt       <= '0;
            valid_o   <= 1'b0;
        end else if (ce_n) begin
            page_open <= 1'b0;
            cnt       <= '0;
            valid_o   <= 1'b0;
        end else if (new_page) begin
            page_open <= 1'b1;
            open_tag  <= tag;
            last_sel  <= sel;
            cnt       <= CW'(FULL_LAT - 1);
            valid_o   <= 1'b0;
        end else if (new_sel) begin
            last_sel  <= sel;
            cnt       <= CW'(PAGE_LAT - 1);
            valid_o   <= 1'b0;
        end else if (cnt != '0) begin
            cnt       <= cnt - 1'b1;
        end else begin
            valid_o   <= 1'b1;
        end
    end

endmodule

// File: rtl/pgrom_outmux.sv
// Output stage. It captures the selected word or byte at each load and gates each half with its enable.
// Assumes that the inputs at a load edge match those the timer last latched.
module pgrom_outmux (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [pgrom_pkg::WORD_W-1:0]  word_in,
    input  logic                          word_mode,
    input  logic                          bsel,
    input  logic                          ce_n,
    input  logic                          oe_n,
    output logic [pgrom_pkg::WORD_W-1:0]  dq_o,
    output logic                          dq_oe_lo,
    output logic                          dq_oe_hi
);
    localparam int BW = pgrom_pkg::BYTE_W;

    logic [pgrom_pkg::WORD_W-1:0] data_q;
    logic [pgrom_pkg::WORD_W-1:0] sel_word;

    // Word mode passes the word; byte mode moves the chosen half onto the low lane.
    always_comb begin
        if (word_mode) begin
            sel_word = word_in;
        end else if (bsel) begin
            sel_word = {{BW{1'b0}}, word_in[2*BW-1:BW]};
        end else begin
            sel_word = {{BW{1'b0}}, word_in[BW-1:0]};
        end
    end

    // Hold the returned data between loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= sel_word;
        end
    end

    // Per-half enables and zeroing of the undriven lanes.
    always_comb begin
        dq_oe_lo = !ce_n && !oe_n;
        dq_oe_hi = dq_oe_lo && word_mode;
        dq_o     = {dq_oe_hi ? data_q[2*BW-1:BW] : {BW{1'b0}},
                    dq_oe_lo ? data_q[BW-1:0]    : {BW{1'b0}}};
    end

endmodule

// File: rtl/pgrom_reader.sv
// Top of the page-mode read port.
// It decodes identification mode, builds the page tag and the in-page selector,
// and connects the array, the latency timer and the output stage.
// Assumes FULL_LAT is even and at least 2, and PAGE_WORDS is a power of two.
module pgrom_reader #(
    parameter int          ADDR_W     = 10,
    parameter int          PAGE_WORDS = 8,
    parameter int          FULL_LAT   = 4,
    parameter logic [14:0] MFR_CODE   = 15'h0047,
    parameter logic [14:0] DEV_CODE   = 15'h0C3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bsel,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic              id_req,
    output logic [15:0]       dq_o,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              valid
);
    localparam int PG_BITS  = $clog2(PAGE_WORDS);
    localparam int PAGE_LAT = FULL_LAT / 2;
    localparam int TAG_W    = ADDR_W - PG_BITS + 1;
    localparam int SEL_W    = PG_BITS + 2;

    logic              id_active;
    logic [TAG_W-1:0]  tag;
    logic [SEL_W-1:0]  sel;
    logic [15:0]       rd_word;
    logic [15:0]       word_src;
    logic              load;

    // Identification decode, page tag and in-page selector (bsel masked in word mode).
    always_comb begin
        id_active = id_req && (addr[ADDR_W-1:1] == '0);
        tag       = {id_active, addr[ADDR_W-1:PG_BITS]};
        sel       = {addr[PG_BITS-1:0], word_mode, bsel && !word_mode};
        if (id_active) begin
            word_src = addr[0] ? pgrom_pkg::id_word(DEV_CODE)
                               : pgrom_pkg::id_word(MFR_CODE);
        end else begin
            word_src = rd_word;
        end
    end

    pgrom_store #(.ADDR_W(ADDR_W)) store_i (
        .addr    (addr),
        .rd_word (rd_word)
    );

    pgrom_timer #(
        .TAG_W    (TAG_W),
        .SEL_W    (SEL_W),
        .FULL_LAT (FULL_LAT),
        .PAGE_LAT (PAGE_LAT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .tag     (tag),
        .sel     (sel),
        .load_o  (load),
        .valid_o (valid)
    );

    pgrom_outmux outmux_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word_in   (word_src),
        .word_mode (word_mode),
        .bsel      (bsel),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .dq_o      (dq_o),
        .dq_oe_lo  (dq_oe_lo),
        .dq_oe_hi  (dq_oe_hi)
    );

endmodule

// File: rtl/pgrom_reader_chk.sv
// Property checker for pgrom_reader, bound to every instance.
// Assumes inputs change at most once per clock, away from the rising edge.
module pgrom_reader_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              bsel,
    input logic              ce_n,
    input logic              oe_n,
    input logic              word_mode,
    input logic              id_req,
    input logic [15:0]       dq_o,
    input logic              dq_oe_lo,
    input logic              dq_oe_hi,
    input logic              valid
);
    // R4
    ce_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !valid);

    // R5
    hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode |-> (!dq_oe_hi && dq_o[15:8] == 8'h00));

    // R5
    disabled_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe_lo && !dq_oe_hi && dq_o == 16'h0000));

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !$stable(addr)) |=> !valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && valid && $stable(addr) && $stable(bsel) && $stable(word_mode)
         && $stable(id_req)) |=> valid);

    // R8
    id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && valid && word_mode && id_req && addr[ADDR_W-1:1] == '0
         && $stable(addr) && $stable(id_req) && $stable(word_mode)) |-> (^dq_o));

endmodule

bind pgrom_reader pgrom_reader_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .bsel      (bsel),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .word_mode (word_mode),
    .id_req    (id_req),
    .dq_o      (dq_o),
    .dq_oe_lo  (dq_oe_lo),
    .dq_oe_hi  (dq_oe_hi),
    .valid     (valid)
);

// File: tb/pgrom_reader_tb_top.sv
module pgrom_reader_tb_top;
    localparam int          AW   = 10;
    localparam int          FULL = 4;
    localparam int          PAGE = 2;
    localparam logic [14:0] MFR  = 15'h0047;
    localparam logic [14:0] DEV  = 15'h0C3A;

    typedef struct packed {
        logic [AW-1:0] a;
        logic          bs;
        logic          wm;
        logic          id;
        logic [3:0]    lat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{10'h028, 1'b0, 1'b1, 1'b0, 4'd4},  // first access after ce falls
        '{10'h02B, 1'b0, 1'b1, 1'b0, 4'd2},  // in-page word
        '{10'h02F, 1'b0, 1'b1, 1'b0, 4'd2},  // in-page word
        '{10'h02F, 1'b0, 1'b0, 1'b0, 4'd2},  // switch to byte mode, low byte
        '{10'h02F, 1'b1, 1'b0, 1'b0, 4'd2},  // high byte
        '{10'h031, 1'b1, 1'b0, 1'b0, 4'd4},  // new page in byte mode
        '{10'h031, 1'b0, 1'b1, 1'b0, 4'd2},  // back to word mode
        '{10'h000, 1'b0, 1'b1, 1'b1, 4'd4},  // enter identification: maker
        '{10'h001, 1'b0, 1'b1, 1'b1, 4'd2},  // device code
        '{10'h001, 1'b1, 1'b0, 1'b1, 4'd2},  // device code high byte
        '{10'h003, 1'b0, 1'b1, 1'b1, 4'd4},  // request ignored: array read
        '{10'h000, 1'b0, 1'b1, 1'b0, 4'd2},  // same page 0, array
        '{10'h3FF, 1'b0, 1'b1, 1'b0, 4'd4}   // last page
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          bsel = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b0;
    logic          word_mode = 1'b1;
    logic          id_req = 1'b0;
    logic [15:0]   dq_o;
    logic          dq_oe_lo;
    logic          dq_oe_hi;
    logic          valid;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pgrom_reader #(
        .ADDR_W(AW), .PAGE_WORDS(8), .FULL_LAT(FULL), .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bsel(bsel), .ce_n(ce_n), .oe_n(oe_n),
        .word_mode(word_mode), .id_req(id_req), .dq_o(dq_o), .dq_oe_lo(dq_oe_lo),
        .dq_oe_hi(dq_oe_hi), .valid(valid)
    );

    function automatic logic [15:0] id_model(input logic [14:0] c);
        int ones = 0;
        for (int i = 0; i < 15; i++) ones += int'(c[i]);
        return {(ones % 2 == 0), c};
    endfunction

    function automatic logic [15:0] exp_dq(input logic [AW-1:0] a, input logic bs,
                                           input logic wm, input logic id);
        logic [31:0] prod;
        logic [15:0] w;
        if (id && a[AW-1:1] == '0) begin
            w = a[0] ? id_model(DEV) : id_model(MFR);
        end else begin
            prod = {22'd0, a} * 32'd40503 + 32'd4660;
            w = prod[15:0];
        end
        if (wm) return w;
        return bs ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge and check the valid timing and the data.
    task automatic access(input logic [AW-1:0] a, input logic bs, input logic wm,
                          input logic id, input int lat, input string req);
        logic [15:0] e;
        e = exp_dq(a, bs, wm, id);
        addr = a; bsel = bs; word_mode = wm; id_req = id; ce_n = 1'b0;
        repeat (lat) @(posedge clk);
        @(negedge clk);
        chk(!valid, {req, " valid still low before latency"}, 32'(valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(valid, {req, " valid at latency"}, 32'(valid), 32'd1);
        chk(dq_o == e, {req, " data (R6/R7/R8/R9)"}, 32'(dq_o), 32'(e));
        chk(dq_oe_lo == 1'b1 && dq_oe_hi == wm, "R5 lane enables",
            {30'd0, dq_oe_hi, dq_oe_lo}, {30'd0, wm, 1'b1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!valid && !dq_oe_lo && !dq_oe_hi && dq_o == 16'h0, "R1 reset state",
            {15'd0, valid, dq_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string req;
            if (VECS[i].id && VECS[i].a[AW-1:1] == '0) req = "R8";
            else if (VECS[i].id) req = "R9";
            else if (int'(VECS[i].lat) == FULL) req = "R2";
            else req = "R3";
            access(VECS[i].a, VECS[i].bs, VECS[i].wm, VECS[i].id,
                   int'(VECS[i].lat), req);
        end

        // R4: chip enable high closes the page
        ce_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!valid && !dq_oe_lo, "R4 ce high clears valid", {31'd0, valid}, 32'd0);
        // R2: same address after ce returns needs the full latency
        access(10'h3FF, 1'b0, 1'b1, 1'b0, FULL, "R2 reopen");

        // R10: oe_n toggling leaves timing and data alone
        oe_n = 1'b1;
        #1;
        chk(!dq_oe_lo && !dq_oe_hi && dq_o == 16'h0, "R10 oe high blanks lanes",
            32'(dq_o), 32'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(valid, "R10 valid kept with oe high", 32'(valid), 32'd1);
        oe_n = 1'b0;
        #1;
        chk(dq_o == exp_dq(10'h3FF, 1'b0, 1'b1, 1'b0), "R10 data after oe returns",
            32'(dq_o), 32'(exp_dq(10'h3FF, 1'b0, 1'b1, 1'b0)));

        // R7: bsel toggling in word mode does not restart the access
        @(negedge clk);
        bsel = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(valid && dq_o == exp_dq(10'h3FF, 1'b0, 1'b1, 1'b0),
            "R7 bsel ignored in word mode", {15'd0, valid, dq_o},
            {15'd0, 1'b1, exp_dq(10'h3FF, 1'b0, 1'b1, 1'b0)});

        // R8: maker code has odd parity over all 16 bits
        access(10'h000, 1'b0, 1'b1, 1'b1, FULL, "R8 maker");
        chk(^dq_o, "R8 odd parity", 32'(^dq_o), 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule